// File: doc/BRIEF.md
# Iterative Restoring Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over many clock cycles. It returns a 32-bit quotient on `lo_o` and a 32-bit remainder on `hi_o`. A one-cycle `start_i` pulse loads the operands. `signed_i` chooses between two's-complement and unsigned interpretation. `busy_o` is high while the work is in progress, and `done_o` pulses once when the result registers have been updated.

The datapath has one divisor register, one W-bit subtractor with a magnitude compare, and a double-width working register. The working register holds the dividend at the start, then the partial remainder, and collects quotient bits from the right. It has a single extension bit above it, so divisors with the top bit set still compare correctly. A signed request is handled in three parts:

- Both operands are first reduced to magnitudes.
- The unsigned magnitudes are divided.
- The quotient and remainder signs are applied in a final cycle.

The block makes no overflow or zero-divisor check and raises no flag for either case.

Top module: `iter_divider`

## Requirements
- R1: With `signed_i`=0, the operands are unsigned. `lo_o` is the truncated quotient and `hi_o` is the remainder (dividend minus quotient times divisor).
- R2: With `signed_i`=1, the quotient magnitude is |dividend|/|divisor| truncated. The quotient is negated exactly when the operand sign bits (bit 31) differ.
- R3: With `signed_i`=1, the remainder has magnitude |dividend| mod |divisor| and takes the sign of the dividend.
- R4: A zero divisor raises no error. `hi_o` equals the dividend. `lo_o` is 32'hFFFFFFFF, except in signed mode with a negative dividend, where it is 32'h00000001.
- R5: In signed mode, the dividend 32'h80000000 divided by 32'hFFFFFFFF gives `lo_o`=32'h80000000 and `hi_o`=0.
- R6: A start sampled at a clock edge while `busy_o` is low sets `busy_o` from that edge. `done_o` rises at the 34th edge after it, and `busy_o` falls at that same edge. `busy_o` and `done_o` are never high together.
- R7: `done_o` is high for exactly one cycle per accepted request.
- R8: A start sampled while `busy_o` is high is ignored. It changes neither the running operation nor its result.
- R9: `hi_o` and `lo_o` change only at the edge where `done_o` rises, and hold their values otherwise.
- R10: A synchronous active-high `rst` clears `busy_o`, `done_o`, `hi_o` and `lo_o`.
- R11: A start sampled in the cycle in which `done_o` is high is accepted and runs with the R6 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse, sampled when not busy |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled with the start |
| divisor_i | input | 32 | Divisor, sampled with the start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse: new result on hi_o/lo_o |
| hi_o | output | 32 | Remainder of the last completed division |
| lo_o | output | 32 | Quotient of the last completed division |

## Verification
Two events can share a cycle: the completion pulse of one request and the acceptance of the next one. The bench provokes this by having its driver raise `start_i` at the first falling edge where `busy_o` is low, which is the same cycle in which `done_o` is high. The monitor then checks two things for each request: that the result popped at that completion belongs to the earlier request, and that the new request finishes exactly 34 edges later with its own values. A second overlap occurs when a start arrives mid-run. It is judged by checking that the running result is unchanged and that its latency does not shift.

// File: rtl/div_pkg.sv
package div_pkg;
  // Controller phases: waiting, iterating, applying signs.
  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_FIX  = 2'd2
  } dv_state_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         quo_neg,
  output logic         rem_neg
);
  // Two's-complement magnitude when the value is treated as signed.
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic as_signed);
    return (as_signed && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    dvd_mag = magnitude(dvd, signed_mode);
    dvs_mag = magnitude(dvs, signed_mode);
    quo_neg = signed_mode && (dvd[W-1] ^ dvs[W-1]);
    rem_neg = signed_mode && dvd[W-1];
  end
endmodule

// File: rtl/div_iter_step.sv
module div_iter_step #(
  parameter int W = 32
) (
  input  logic         first,
  input  logic         ext,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvs,
  output logic         nxt_ext,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo,
  output logic         qbit
);
  logic         fits;
  logic [W-1:0] trial;
  logic [W-1:0] keep;

  // The partial remainder is W+1 bits wide ({ext,hi}); when the divisor
  // fits, the true difference is below 2**W so a W-bit subtract suffices.
  always_comb begin
    fits    = ({ext, hi} >= {1'b0, dvs});
    trial   = hi - dvs;
    qbit    = fits && !first;
    keep    = qbit ? trial : hi;
    {nxt_ext, nxt_hi, nxt_lo} = {keep, lo, qbit};
  end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int W = 32
) (
  input  logic         ext,
  input  logic [W-2:0] hi_top,
  input  logic [W-1:0] lo,
  input  logic         quo_neg,
  input  logic         rem_neg,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  // Upper half was shifted once too often: undo by taking {ext,hi} >> 1.
  always_comb begin
    quo = apply_sign(lo, quo_neg);
    rem = apply_sign({ext, hi_top}, rem_neg);
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  import div_pkg::*;

  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  dv_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ext_q;
  logic [W-1:0]     wh_q, wl_q, dvs_q;
  logic             qneg_q, rneg_q;

  logic [W-1:0] dvd_mag, dvs_mag;
  logic         quo_neg, rem_neg;
  logic         n_ext, qbit_w;
  logic [W-1:0] n_hi, n_lo;
  logic [W-1:0] quo_w, rem_w;

  // Named events for the checker.
  logic accept_w;
  logic last_step_w;

  assign busy_o      = (state_q != DV_IDLE);
  assign accept_w    = start_i && (state_q == DV_IDLE);
  assign last_step_w = (state_q == DV_RUN) && (cnt_q == LAST);

  div_operand_prep #(.W(W)) u_prep (
    .signed_mode(signed_i), .dvd(dividend_i), .dvs(divisor_i),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .quo_neg(quo_neg), .rem_neg(rem_neg)
  );

  div_iter_step #(.W(W)) u_step (
    .first(cnt_q == '0), .ext(ext_q), .hi(wh_q), .lo(wl_q), .dvs(dvs_q),
    .nxt_ext(n_ext), .nxt_hi(n_hi), .nxt_lo(n_lo), .qbit(qbit_w)
  );

  div_result_fix #(.W(W)) u_fix (
    .ext(ext_q), .hi_top(wh_q[W-1:1]), .lo(wl_q),
    .quo_neg(qneg_q), .rem_neg(rneg_q), .quo(quo_w), .rem(rem_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DV_IDLE;
      cnt_q   <= '0;
      ext_q   <= 1'b0;
      wh_q    <= '0;
      wl_q    <= '0;
      dvs_q   <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      hi_o    <= '0;
      lo_o    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        DV_IDLE: if (accept_w) begin
          ext_q   <= 1'b0;
          wh_q    <= '0;
          wl_q    <= dvd_mag;
          dvs_q   <= dvs_mag;
          qneg_q  <= quo_neg;
          rneg_q  <= rem_neg;
          cnt_q   <= '0;
          state_q <= DV_RUN;
        end
        DV_RUN: begin
          ext_q <= n_ext;
          wh_q  <= n_hi;
          wl_q  <= n_lo;
          cnt_q <= cnt_q + 1'b1;
          if (last_step_w) state_q <= DV_FIX;
        end
        DV_FIX: begin
          hi_o    <= rem_w;
          lo_o    <= quo_w;
          done_o  <= 1'b1;
          state_q <= DV_IDLE;
        end
        default: state_q <= DV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_check.sv
module div_check #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o,
  input logic [W-1:0] dvs_q,
  input logic         accept_w,
  input logic         last_step_w
);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && hi_o == '0 && lo_o == '0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> busy_o);

  p_last_then_done_r6: assert property (@(posedge clk) disable iff (rst)
    last_step_w |=> ##1 done_o);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> $stable(dvs_q));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind iter_divider div_check #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .hi_o(hi_o), .lo_o(lo_o), .dvs_q(dvs_q), .accept_w(accept_w),
  .last_step_w(last_step_w)
);

// File: tb/sim_iter_divider.sv
module sim_iter_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  iter_divider #(.W(32)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int r7_err = 0;
  int r9_err = 0;
  logic        prev_done = 1'b0;
  logic [31:0] last_hi = '0, last_lo = '0;

  // Scoreboard queues, one entry per accepted request.
  logic [31:0] exp_q[$];
  logic [31:0] exp_r[$];
  int          t0_q[$];
  bit          b2b_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input logic sg);
    logic [31:0] q, r;
    int sa, sb;
    if (b == 32'd0) begin
      q = (sg && a[31]) ? 32'd1 : 32'hFFFF_FFFF;
      r = a;
    end else if (sg) begin
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
        q = 32'h8000_0000;
        r = 32'd0;
      end else begin
        sa = $signed(a);
        sb = $signed(b);
        q = 32'(sa / sb);
        r = 32'(sa % sb);
      end
    end else begin
      q = a / b;
      r = a % b;
    end
    return {r, q};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sg, input string tag);
    logic [63:0] e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    e = model(a, b, sg);
    b2b_q.push_back(done_o);
    exp_q.push_back(e[31:0]);
    exp_r.push_back(e[63:32]);
    t0_q.push_back(cyc);
    tag_q.push_back(tag);
    start_i = 1'b1; dividend_i = a; divisor_i = b; signed_i = sg;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: pops one expected item per completion.
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o && prev_done) r7_err++;
      if (!done_o && (hi_o != last_hi || lo_o != last_lo)) r9_err++;
      if (done_o) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R7: unexpected done, actual q=%h r=%h expected no result", lo_o, hi_o);
        end else begin
          logic [31:0] eq, er;
          int t0, lat;
          bit b2b;
          string tg;
          eq = exp_q.pop_front(); er = exp_r.pop_front();
          t0 = t0_q.pop_front(); b2b = b2b_q.pop_front(); tg = tag_q.pop_front();
          lat = cyc - t0;
          checks++;
          if (lo_o !== eq || hi_o !== er) begin
            fails++;
            $display("FAIL %s: actual q=%h r=%h expected q=%h r=%h", tg, lo_o, hi_o, eq, er);
          end
          checks++;
          // Issue falling edge, then accept edge plus 34 edges: 35 counts.
          if (lat != 35) begin
            fails++;
            $display("FAIL %s: latency actual %0d expected 35", b2b ? "R11" : "R6", lat);
          end
        end
      end
      prev_done <= done_o;
      last_hi <= hi_o;
      last_lo <= lo_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] ra, rb;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;  // R10 reset state
    if (busy_o || done_o || hi_o != 0 || lo_o != 0) begin
      fails++;
      $display("FAIL R10: actual busy=%b done=%b hi=%h lo=%h expected all zero", busy_o, done_o, hi_o, lo_o);
    end

    issue(32'd100, 32'd7, 1'b0, "R1");
    issue(32'hFFFF_FFFF, 32'd1, 1'b0, "R1");
    issue(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R1");
    issue(32'd5, 32'd9, 1'b0, "R1");
    issue(32'hDEAD_BEEF, 32'h0000_1234, 1'b0, "R1");
    issue(32'hF000_0000, 32'hC000_0000, 1'b0, "R1");

    issue(-32'sd100, 32'd7, 1'b1, "R2");
    issue(32'd100, -32'sd7, 1'b1, "R2");
    issue(-32'sd100, -32'sd7, 1'b1, "R3");
    issue(32'd7, -32'sd100, 1'b1, "R3");
    issue(-32'sd7, 32'd100, 1'b1, "R3");
    issue(32'h8000_0000, 32'd1, 1'b1, "R2");
    issue(32'h8000_0000, 32'd3, 1'b1, "R3");
    issue(32'hFFFF_FFFF, 32'd1, 1'b1, "R2");
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R5");

    issue(32'd1234, 32'd0, 1'b0, "R4");
    issue(-32'sd5, 32'd0, 1'b1, "R4");
    issue(32'd5, 32'd0, 1'b1, "R4");

    // R8: second start mid-run must not disturb the first request.
    issue(32'd1000, 32'd10, 1'b0, "R8");
    repeat (5) @(negedge clk);
    start_i = 1'b1; dividend_i = 32'd7; divisor_i = 32'd7; signed_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;

    seed = 32'h1357_9BDF;
    for (int i = 0; i < 20; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      ra = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      rb = seed >> seed[4:0];
      issue(ra, rb, i[0], i[0] ? "R2" : "R1");
    end

    @(negedge clk);
    while (busy_o || exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);

    checks++;
    if (r7_err != 0) begin
      fails++;
      $display("FAIL R7: actual %0d multi-cycle done pulses expected 0", r7_err);
    end
    checks++;
    if (r9_err != 0) begin
      fails++;
      $display("FAIL R9: actual %0d result changes outside done expected 0", r9_err);
    end
    finish_run();
  end
endmodule